// File: doc/BRIEF.md
# DS3 Transmit Line Encoder

This block sits between a DS3 transmit framer and an external line interface device. It takes the outbound serial bit stream, one bit per enabled line clock, and drives a positive rail and a negative rail. Both rails are registered on the transmit line clock, which runs at 44.736 MHz for DS3. The line code can be changed at run time. It can be single-rail (unipolar), alternate mark inversion (AMI), or bipolar with three-zero substitution (B3ZS).

A disable input bypasses the coding. The raw bits then go out on the positive rail, so that a line interface device with its own encoder can do the coding. Three-zero substitution needs to see a full run of zeros before it decides what to send. For that reason every bit passes through a three-stage window, and every mode has the same fixed latency. Changing the mode therefore never shifts the output timing.

Top module: `ds3_line_encoder`

## Requirements
- R1: The select input `code_sel_i` is decoded as follows: 2'b00 gives unipolar, 2'b01 gives AMI, 2'b10 gives B3ZS, and 2'b11 gives unipolar. In unipolar mode `pos_o` carries the data bit and `neg_o` stays low.
- R2: In AMI mode each 1 is sent as a mark on one rail, and successive marks alternate rails. Each 0 leaves both rails low, even inside long runs of zeros.
- R3: In B3ZS mode each run of three consecutive zeros that is not already part of a substitution is replaced. The replacement is B0V when an even number of marks has been sent since the last substitution (or since reset), and 00V when that number is odd.
- R4: In B3ZS mode a V takes the rail of the mark sent just before it. A B, and every ordinary mark, takes the rail opposite to the mark sent just before it.
- R5: While `enc_dis_i` is high the block behaves as unipolar, whatever the value of `code_sel_i`.
- R6: A bit accepted at enabled clock edge k is output after enabled edge k+3, in every mode.
- R7: While `en_i` is low the rails, the window and the polarity state all hold their values.
- R8: `pos_o` and `neg_o` are never high in the same cycle.
- R9: While `rst_ni` is low both rails are low, without waiting for a clock edge. After reset the first mark goes on `pos_o`, and the mark count starts at even.
- R10: When the effective mode of an emitted bit differs from that of the previous emitted bit, the polarity and parity state restart. The next mark then goes on `pos_o`, and the count starts at even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit line clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Line clock enable: one bit accepted per high cycle |
| data_i | input | 1 | Serial outbound data bit |
| code_sel_i | input | 2 | Line-code select (see R1) |
| enc_dis_i | input | 1 | Encoder bypass: forces unipolar output |
| pos_o | output | 1 | Positive rail |
| neg_o | output | 1 | Negative rail |

## Verification
The assertions are checked on every cycle and cover local relations:
- the rails are never both high;
- the rails hold while the clock enable is low;
- the negative rail stays quiet in unipolar or bypass mode;
- a zero with no substitution tag produces no mark;
- a substitution V repeats the polarity of the preceding mark;
- a completed zero run leaves the whole window zero.

Other properties can only be shown by the bench's scenarios, because they depend on a whole sequence of bits:
- the choice between B0V and 00V, which depends on the parity of the marks sent;
- the exact three-clock alignment of each output bit;
- the positive first mark after a reset or after a mode change.

// File: rtl/ds3_enc_pkg.sv
package ds3_enc_pkg;
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_UNI  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_AMI  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_B3ZS = 2'b10;

  typedef enum logic [1:0] {
    MODE_UNI,
    MODE_AMI,
    MODE_B3ZS
  } mode_e;

  // position of a bit inside a zero-substitution group
  typedef enum logic [1:0] {
    TAG_NONE,
    TAG_FIRST,
    TAG_MID,
    TAG_LAST
  } tag_e;
endpackage

// File: rtl/ds3_enc_window.sv
module ds3_enc_window
  import ds3_enc_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic data_i,
  output logic out_bit_o,
  output tag_e out_tag_o
);
  localparam int unsigned CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(DEPTH - 1);

  logic [DEPTH-1:0] bit_q;
  tag_e             tag_q [DEPTH];
  logic [CW-1:0]    zrun_q;
  logic             run_done;

  // zrun_q counts untagged zeros already in the window
  assign run_done = !data_i && (zrun_q == RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q <= '0;
    end else if (en_i) begin
      if (data_i || run_done) zrun_q <= '0;
      else                    zrun_q <= zrun_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= TAG_NONE;
    end else if (en_i) begin
      bit_q <= {bit_q[DEPTH-2:0], data_i};
      tag_q[0] <= run_done ? TAG_LAST : TAG_NONE;
      for (int i = 1; i < DEPTH; i++) begin
        if (run_done) tag_q[i] <= (i == DEPTH - 1) ? TAG_FIRST : TAG_MID;
        else          tag_q[i] <= tag_q[i-1];
      end
    end
  end

  assign out_bit_o = bit_q[DEPTH-1];
  assign out_tag_o = tag_q[DEPTH-1];

  // a completed run fills the whole window with zeros
  assert_sub_group_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_done) |=> (bit_q == '0));
endmodule

// File: rtl/ds3_enc_mode.sv
module ds3_enc_mode
  import ds3_enc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] code_sel_i,
  input  logic             enc_dis_i,
  output mode_e            mode_o,
  output logic             restart_o
);
  mode_e mode_q;

  always_comb begin
    if (enc_dis_i)                  mode_o = MODE_UNI;
    else if (code_sel_i == SEL_AMI)  mode_o = MODE_AMI;
    else if (code_sel_i == SEL_B3ZS) mode_o = MODE_B3ZS;
    else                             mode_o = MODE_UNI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_UNI;
    else if (en_i) mode_q <= mode_o;
  end

  assign restart_o = (mode_o != mode_q);
endmodule

// File: rtl/ds3_enc_out.sv
module ds3_enc_out
  import ds3_enc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  mode_e mode_i,
  input  logic  restart_i,
  input  logic  bit_i,
  input  tag_e  tag_i,
  output logic  pos_o,
  output logic  neg_o
);
  logic next_pos_q, odd_q;
  logic np, od, np_d, od_d, pos_d, neg_d;

  always_comb begin
    np    = restart_i ? 1'b1 : next_pos_q;
    od    = restart_i ? 1'b0 : odd_q;
    np_d  = np;
    od_d  = od;
    pos_d = 1'b0;
    neg_d = 1'b0;
    unique case (mode_i)
      MODE_AMI: begin
        if (bit_i) begin
          pos_d = np;
          neg_d = !np;
          np_d  = !np;
        end
      end
      MODE_B3ZS: begin
        unique case (tag_i)
          TAG_NONE: begin
            if (bit_i) begin
              pos_d = np;
              neg_d = !np;
              np_d  = !np;
              od_d  = !od;
            end
          end
          TAG_FIRST: begin
            if (!od) begin // even count: B pulse
              pos_d = np;
              neg_d = !np;
              np_d  = !np;
            end
          end
          TAG_MID: ;
          TAG_LAST: begin // V repeats last mark polarity
            pos_d = !np;
            neg_d = np;
            od_d  = 1'b0;
          end
          default: ;
        endcase
      end
      default: pos_d = bit_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pos_q <= 1'b1;
      odd_q      <= 1'b0;
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
    end else if (en_i) begin
      next_pos_q <= np_d;
      odd_q      <= od_d;
      pos_o      <= pos_d;
      neg_o      <= neg_d;
    end
  end

  assert_rails_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));

  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pos_o) && $stable(neg_o)));

  assert_unipolar_neg_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_UNI) |=> !neg_o);

  assert_zero_no_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i != MODE_UNI && !bit_i && tag_i == TAG_NONE) |=> (!pos_o && !neg_o));

  assert_violation_polarity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_B3ZS && tag_i == TAG_LAST && !restart_i)
      |=> (pos_o == !$past(next_pos_q)) && (neg_o == $past(next_pos_q)));
endmodule

// File: rtl/ds3_line_encoder.sv
module ds3_line_encoder
  import ds3_enc_pkg::*;
#(
  parameter int unsigned SUB_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             data_i,
  input  logic [SEL_W-1:0] code_sel_i,
  input  logic             enc_dis_i,
  output logic             pos_o,
  output logic             neg_o
);
  logic  win_bit;
  tag_e  win_tag;
  mode_e mode;
  logic  restart;

  ds3_enc_window #(.DEPTH(SUB_LEN)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .data_i    (data_i),
    .out_bit_o (win_bit),
    .out_tag_o (win_tag)
  );

  ds3_enc_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .code_sel_i (code_sel_i),
    .enc_dis_i  (enc_dis_i),
    .mode_o     (mode),
    .restart_o  (restart)
  );

  ds3_enc_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode),
    .restart_i (restart),
    .bit_i     (win_bit),
    .tag_i     (win_tag),
    .pos_o     (pos_o),
    .neg_o     (neg_o)
  );

  assert_bypass_single_rail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && enc_dis_i) |=> !neg_o);
endmodule

// File: tb/ds3_line_encoder_tb_top.sv
`timescale 1ns/1ps
module ds3_line_encoder_tb_top;
  localparam int NBITS = 12;
  localparam int LAT   = 3;
  localparam int WD_CYCLES = 100000;

  typedef struct packed {
    logic [1:0]       sel;
    logic             dis;
    logic [NBITS-1:0] data;    // leftmost bit sent first
    logic [NBITS-1:0] exp_pos;
    logic [NBITS-1:0] exp_neg;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    // R1 unipolar
    '{2'b00, 1'b0, 12'b101100100111, 12'b101100100111, 12'b000000000000},
    // R2 AMI alternation
    '{2'b01, 1'b0, 12'b110100011011, 12'b100100001001, 12'b010000010010},
    // R3 R4 B3ZS: B0V, 00V, B0V
    '{2'b10, 1'b0, 12'b000100011000, 12'b101000010101, 12'b000100101000},
    // R3 R4 B3ZS long zero runs: 00V, B0V, 00V
    '{2'b10, 1'b0, 12'b100000010000, 12'b100100010010, 12'b000010100000},
    // R5 bypass with B3ZS selected
    '{2'b10, 1'b1, 12'b100011000101, 12'b100011000101, 12'b000000000000},
    // R2 AMI keeps zero runs empty
    '{2'b01, 1'b0, 12'b000100001110, 12'b000100000100, 12'b000000001010},
    // R1 reserved select code acts as unipolar
    '{2'b11, 1'b0, 12'b010100000110, 12'b010100000110, 12'b000000000000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic data = 1'b0;
  logic [1:0] sel = 2'b00;
  logic dis = 1'b0;
  logic pos, neg;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ds3_line_encoder dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .data_i     (data),
    .code_sel_i (sel),
    .enc_dis_i  (dis),
    .pos_o      (pos),
    .neg_o      (neg)
  );

  task automatic check(input string req, input logic [NBITS-1:0] act,
                       input logic [NBITS-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic e, input logic d);
    en = e;
    data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(WD_CYCLES * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NBITS-1:0] ap, an;
    @(negedge clk);
    do_reset();
    // R9 reset state
    check("R9", {10'b0, pos, neg}, '0, "rails after reset");

    // vector walk: R6 alignment checked in every mode
    for (int v = 0; v < NVEC; v++) begin
      sel = VECS[v].sel;
      dis = VECS[v].dis;
      do_reset();
      ap = '0;
      an = '0;
      for (int c = 0; c < NBITS + LAT; c++) begin
        tick(1'b1, (c < NBITS) ? VECS[v].data[NBITS-1-c] : 1'b1);
        if (c >= LAT) begin
          ap[NBITS-1-(c-LAT)] = pos;
          an[NBITS-1-(c-LAT)] = neg;
        end
      end
      check("R6", ap, VECS[v].exp_pos, $sformatf("vector %0d pos rail", v));
      check("R6", an, VECS[v].exp_neg, $sformatf("vector %0d neg rail", v));
    end

    // R7 clock enable stall: bits 1,1,0,1 in AMI
    sel = 2'b01; dis = 1'b0;
    do_reset();
    tick(1'b1, 1'b1); tick(1'b1, 1'b1); tick(1'b1, 1'b0); tick(1'b1, 1'b1);
    check("R7", {10'b0, pos, neg}, 12'b10, "first mark before stall");
    ap = '0;
    for (int s = 0; s < 3; s++) begin
      tick(1'b0, 1'b1);
      if (pos !== 1'b1 || neg !== 1'b0) ap = 12'hfff;
    end
    check("R7", ap, '0, "rails moved while enable low");
    tick(1'b1, 1'b1);
    check("R7", {10'b0, pos, neg}, 12'b01, "bit1 after stall");
    tick(1'b1, 1'b1);
    check("R7", {10'b0, pos, neg}, 12'b00, "bit2 zero after stall");
    tick(1'b1, 1'b1);
    check("R7", {10'b0, pos, neg}, 12'b10, "bit3 after stall");

    // R10 mode change restarts polarity
    sel = 2'b01;
    do_reset();
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
    check("R10", {10'b0, pos, neg}, 12'b10, "AMI first mark");
    sel = 2'b10;
    tick(1'b1, 1'b1);
    check("R10", {10'b0, pos, neg}, 12'b10, "first mark after mode change");
    tick(1'b1, 1'b1);
    check("R10", {10'b0, pos, neg}, 12'b01, "second mark after mode change");

    // R9 asynchronous reset mid stream
    sel = 2'b01;
    do_reset();
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R9", {10'b0, pos, neg}, 12'b00, "rails low in reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
    check("R9", {10'b0, pos, neg}, 12'b10, "first mark after reset");
    tick(1'b1, 1'b1);
    check("R8", {10'b0, pos, neg}, 12'b01, "second mark after reset");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule